// File: doc/BRIEF.md
# Sync-Timed Data-Enable Generator

This block runs in the pixel clock domain. It builds a data-enable strobe for a video source that provides only horizontal and vertical sync. A pixel index restarts at each active horizontal sync edge, and a line index restarts at each active vertical sync edge. The strobe is raised inside a programmed rectangle. That rectangle is described by a horizontal offset and width in pixels and a vertical offset and height in lines.

The same counters also measure the stream all the time. The block reports the pixel count of the last complete line and the line count of the last complete frame, whether or not generation is enabled. When generation is disabled, the external data-enable input is passed through instead. Either way, the output strobe is registered, so it lines up with pixel data that has been delayed by one clock.

Top module: `sync_de_gen`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `de_out`, `h_total` and `v_total` read 0.
- R2: A sync is active when its input equals its polarity bit (0 = active low, 1 = active high). An active edge is the cycle in which the sync first shows its active level after an inactive cycle.
- R3: The pixel index is 0 in the cycle of an active `hsync` edge. Otherwise it is the previous index plus one, saturating at 2047.
- R4: The line index is 0 in the cycle of an active `vsync` edge. Otherwise it grows by one in each active `hsync` edge cycle, saturating at 2047. When both edges fall in the same cycle, the vertical reset wins.
- R5: With generation enabled, `de_out` is high one clock after a cycle whose pixel index p and line index l meet two conditions: `h_start` <= p < `h_start`+`h_width`, and `v_start` <= l < `v_start`+`v_height`.
- R6: A zero `h_width` or a zero `v_height` keeps `de_out` low for as long as generation is enabled.
- R7: With `gen_en` low, `de_out` equals `ext_de` delayed by one clock. With `gen_en` high, `ext_de` has no effect on `de_out`.
- R8: On each active `hsync` edge, `h_total` takes the previous pixel index plus one, saturating at 2047. It is visible on the next clock and held between edges.
- R9: On each active `vsync` edge, `v_total` takes the previous line index plus one, saturating at 2047. When the syncs start together, this is the line count per frame.
- R10: Both measurements are updated identically whether `gen_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | 1 = generate the strobe internally, 0 = pass `ext_de` through |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| ext_de | input | 1 | Externally supplied data enable |
| h_start | input | 9 | Pixels from the horizontal edge to the first active pixel |
| h_width | input | 11 | Active pixels per line |
| v_start | input | 8 | Lines from the vertical edge to the first active line |
| v_height | input | 11 | Active lines per frame |
| de_out | output | 1 | Registered data enable |
| h_total | output | 11 | Measured pixels per line |
| v_total | output | 11 | Measured lines per frame |

## Verification
A frame start brings the horizontal and the vertical active edges together in one cycle. In that cycle the line index must clear rather than increment, and both measurements must latch. The bench drives frames whose first pixel carries both edges, under both polarity settings. It then checks three things: that the first active line sits exactly `v_start` lines after the frame start, that the per-pixel strobe pattern holds, and that `h_total` and `v_total` equal the driven line length and frame height.

// File: rtl/sync_de_gen.sv
module sync_de_gen #(
  parameter int CNT_W  = 11,
  parameter int HOFF_W = 9,
  parameter int VOFF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              ext_de,
  input  logic [HOFF_W-1:0] h_start,
  input  logic [CNT_W-1:0]  h_width,
  input  logic [VOFF_W-1:0] v_start,
  input  logic [CNT_W-1:0]  v_height,
  output logic              de_out,
  output logic [CNT_W-1:0]  h_total,
  output logic [CNT_W-1:0]  v_total
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic hs_act, vs_act, hs_prev, vs_prev, hs_edge, vs_edge, live;
  logic [CNT_W-1:0] pix_q, line_q, pix_inc, line_inc, pix_now, line_now;
  logic [SUM_W-1:0] h_lo, h_hi, v_lo, v_hi;
  logic in_win;

  assign hs_act  = (hsync == hs_pol);
  assign vs_act  = (vsync == vs_pol);
  assign hs_edge = hs_act & ~hs_prev;
  assign vs_edge = vs_act & ~vs_prev;

  assign pix_inc  = (pix_q == CNT_MAX)  ? CNT_MAX : pix_q + 1'b1;
  assign line_inc = (line_q == CNT_MAX) ? CNT_MAX : line_q + 1'b1;
  assign pix_now  = hs_edge ? '0 : pix_inc;
  assign line_now = vs_edge ? '0 : (hs_edge ? line_inc : line_q);

  assign h_lo   = SUM_W'(h_start);
  assign h_hi   = h_lo + SUM_W'(h_width);
  assign v_lo   = SUM_W'(v_start);
  assign v_hi   = v_lo + SUM_W'(v_height);
  assign in_win = (SUM_W'(pix_now) >= h_lo) && (SUM_W'(pix_now) < h_hi) &&
                  (SUM_W'(line_now) >= v_lo) && (SUM_W'(line_now) < v_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
      de_out  <= 1'b0;
      h_total <= '0;
      v_total <= '0;
      live    <= 1'b0;
    end else begin
      hs_prev <= hs_act;
      vs_prev <= vs_act;
      pix_q   <= pix_now;
      line_q  <= line_now;
      de_out  <= gen_en ? in_win : ext_de;
      if (hs_edge) h_total <= pix_inc;
      if (vs_edge) v_total <= line_inc;
      live    <= 1'b1;
    end
  end

  // R3
  pix_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> pix_q == '0);

  // R4
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> line_q == '0);

  // R6
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && (h_width == '0 || v_height == '0)) |=> !de_out);

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !gen_en) |=> de_out == $past(ext_de));

  // R8
  htotal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !hs_edge) |=> $stable(h_total));

  // R9
  vtotal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !vs_edge) |=> $stable(v_total));
endmodule

// File: tb/sync_de_gen_bench.sv
module sync_de_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b1, hs_pol = 1'b1, vs_pol = 1'b1;
  logic hsync = 1'b0, vsync = 1'b0, ext_de = 1'b0;
  logic [8:0]  h_start = '0;
  logic [10:0] h_width = '0;
  logic [7:0]  v_start = '0;
  logic [10:0] v_height = '0;
  logic de_out;
  logic [10:0] h_total, v_total;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  sync_de_gen u_sync_de_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hsync(hsync), .vsync(vsync), .ext_de(ext_de), .h_start(h_start),
    .h_width(h_width), .v_start(v_start), .v_height(v_height),
    .de_out(de_out), .h_total(h_total), .v_total(v_total));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_reset(input bit hp, input bit vp);
    @(negedge clk);
    rst_n = 1'b0; hs_pol = hp; vs_pol = vp;
    hsync = ~hp; vsync = ~vp; ext_de = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive frames; hsync active for pixels 0..2, vsync active for lines 0..1
  task automatic run_frames(input int nf, input int htot, input int vtot, input string req);
    bit have = 0;
    bit exp_prev = 0;
    for (int f = 0; f < nf; f++)
      for (int l = 0; l < vtot; l++)
        for (int p = 0; p < htot; p++) begin
          @(negedge clk);
          if (have) check(de_out == exp_prev, req, de_out, exp_prev);
          hsync  = (p < 3) ? hs_pol : ~hs_pol;
          vsync  = (l < 2) ? vs_pol : ~vs_pol;
          ext_de = ((l * 7 + p) % 3) == 0;
          if (gen_en)
            exp_prev = (p >= int'(h_start)) && (p < int'(h_start) + int'(h_width)) &&
                       (l >= int'(v_start)) && (l < int'(v_start) + int'(v_height));
          else
            exp_prev = ext_de;
          have = 1;
        end
    @(negedge clk);
    check(de_out == exp_prev, req, de_out, exp_prev);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(de_out == 1'b0, "R1 de_out", de_out, 0);
    check(h_total == 0, "R1 h_total", h_total, 0);
    check(v_total == 0, "R1 v_total", v_total, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(de_out == 1'b0, "R1 de_out after release", de_out, 0);
  endtask

  task automatic t_high_pol();
    do_reset(1'b1, 1'b1);
    gen_en = 1'b1; h_start = 9'd5; h_width = 11'd20; v_start = 8'd3; v_height = 11'd10;
    run_frames(2, 40, 20, "R5 R7 window active-high");
    check(h_total == 40, "R8 h_total active-high", h_total, 40);
    check(v_total == 20, "R9 v_total active-high", v_total, 20);
  endtask

  task automatic t_low_pol();
    do_reset(1'b0, 1'b0);
    gen_en = 1'b1; h_start = 9'd0; h_width = 11'd7; v_start = 8'd0; v_height = 11'd4;
    run_frames(2, 36, 16, "R2 R4 window active-low");
    check(h_total == 36, "R2 R8 h_total active-low", h_total, 36);
    check(v_total == 16, "R2 R9 v_total active-low", v_total, 16);
  endtask

  task automatic t_edge_window();
    do_reset(1'b1, 1'b0);
    gen_en = 1'b1; h_start = 9'd35; h_width = 11'd20; v_start = 8'd17; v_height = 11'd9;
    run_frames(2, 40, 20, "R3 R5 window clipped by sync");
  endtask

  task automatic t_zero_size();
    do_reset(1'b1, 1'b1);
    gen_en = 1'b1; h_start = 9'd2; h_width = 11'd0; v_start = 8'd0; v_height = 11'd10;
    run_frames(1, 40, 20, "R6 zero width");
    h_width = 11'd10; v_height = 11'd0;
    do_reset(1'b1, 1'b1);
    run_frames(1, 40, 20, "R6 zero height");
  endtask

  task automatic t_pass();
    do_reset(1'b0, 1'b1);
    gen_en = 1'b0; h_start = 9'd1; h_width = 11'd5; v_start = 8'd1; v_height = 11'd5;
    run_frames(2, 30, 12, "R7 pass-through");
    check(h_total == 30, "R10 h_total while disabled", h_total, 30);
    check(v_total == 12, "R10 v_total while disabled", v_total, 12);
  endtask

  task automatic t_saturate();
    do_reset(1'b1, 1'b1);
    gen_en = 1'b1;
    repeat (2100) @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    check(h_total == 2047, "R3 R8 saturated line length", h_total, 2047);
    @(negedge clk);
    hsync = 1'b0;
    repeat (7) @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    check(h_total == 9, "R8 short line after saturation", h_total, 9);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_high_pol();
    t_low_pol();
    t_edge_window();
    t_zero_size();
    t_pass();
    t_saturate();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule